// File: doc/BRIEF.md
# Event Timer Controller

This block is a memory-mapped event timer. A 64-bit main counter advances by one on every clock while software has enabled it. Three comparator timers watch the counter. Each timer can fire once (one-shot) or re-arm itself after each match (periodic). Each timer drives one interrupt line. That line is either held while the timer's status flag stays pending (level) or pulsed for one cycle on the match (edge).

Software reaches every register through a single 32-bit port with byte addresses. The port has one write channel and one read channel. A read returns its data one clock after the request. The registers are:

- a fixed identification word and the tick period in femtoseconds;
- a global configuration word that starts and stops the counter;
- a write-1-to-clear status word;
- the two counter halves;
- for each timer, a configuration word, a 64-bit comparator and a 32-bit route word.

A periodic timer keeps its reload interval beside its comparator. A one-shot "load next" control bit sends the comparator write that follows it into that interval. A timer can also be narrowed so that it compares only the low 32 counter bits.

Top module: `event_timer`

## Requirements
- R1: Offset 0x000 reads {VENDOR_ID[15:0], 0, 0, 1, NUM_TIMERS-1 in bits 12:8, REVISION[7:0]}. Bit 13 = 1 marks a 64-bit counter. Offset 0x004 reads TICK_FS, the tick period in femtoseconds (default 69841279).
- R2: Bit 0 of the global configuration word at 0x010 makes the counter add one per clock. While that bit is 0 the counter holds its value. Bit 1 is stored and read back and has no other effect.
- R3: The counter's low word (0x0F0) and high word (0x0F4) are writable. A write to either word takes priority over that cycle's increment.
- R4: Timer n's registers sit at 0x100+0x20*n: configuration at +0x00, comparator low/high at +0x08/+0x0C, route at +0x10. In the configuration word, bit 1 selects level, bit 2 enables the interrupt, bit 3 selects periodic, bit 6 is load-next, bit 8 selects 32-bit compare and bits 13:9 hold a route number. Bits 4 and 5 always read 1. Bits 0, 7, 14, 15 and 31:16 read 0.
- R5: While the counter runs, a timer whose 64-bit comparator equals the counter sets its status bit on the next clock. After reset the comparators read all ones.
- R6: With the 32-bit bit set, only the low 32 bits are compared. The comparator's high word is ignored.
- R7: Status lives at 0x020, with bit n for timer n. Writing 1 clears a bit and writing 0 leaves it alone. A clear and a match in the same cycle leave the bit set.
- R8: In level mode an enabled timer holds its interrupt high while its status bit is set.
- R9: In edge mode an enabled timer raises its interrupt for exactly the match cycle. The status bit is still set, but the line is not held.
- R10: On each match in periodic mode, the comparator advances by the stored interval. In 32-bit mode only the low word advances.
- R11: With load-next set, a comparator low-word write loads the comparator and clears load-next. The next comparator write goes to the interval, after which writes go to the comparator again. High-word writes follow the same target without moving the sequence.
- R12: A software comparator write in the same cycle as a periodic match wins over the reload.
- R13: A read presents data with rd_valid one clock after rd_en. Any other address, unaligned ones included, reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Byte address of the read |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one clock after rd_en |
| irq_o | output | NUM_TIMERS | Per-timer interrupt lines |

## Verification
Matching is tried with four patterns, and each tells apart two behaviours:

- A one-shot level timer whose comparator is reached after a counted run separates "holds until cleared" from a pulse.
- A counter with a non-zero high word, watched by one full-width timer and one narrowed timer, separates 64-bit from 32-bit comparison.
- A periodic edge timer run for a counted span shows whether the comparator advanced by the interval the right number of times; the pulse count must equal the match count.
- Two collision runs, where a comparator write or a status clear lands on the exact match clock, show which side wins.

// File: rtl/event_timer.sv
module event_timer #(
  parameter int          NUM_TIMERS = 3,
  parameter int          AW         = 10,
  parameter logic [31:0] TICK_FS    = 32'd69841279,
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [7:0]  REVISION   = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [31:0]           wr_data,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  output logic [31:0]           rd_data,
  output logic                  rd_valid,
  output logic [NUM_TIMERS-1:0] irq_o
);
  localparam int NT = NUM_TIMERS;
  localparam logic [4:0]    NT_M1  = 5'(NT - 1);
  localparam logic [AW-1:0] A_ID   = AW'('h000);
  localparam logic [AW-1:0] A_TICK = AW'('h004);
  localparam logic [AW-1:0] A_GCFG = AW'('h010);
  localparam logic [AW-1:0] A_STS  = AW'('h020);
  localparam logic [AW-1:0] A_CLO  = AW'('h0F0);
  localparam logic [AW-1:0] A_CHI  = AW'('h0F4);

  logic [1:0]           gcfg_q;
  logic [63:0]          cnt_q;
  logic [NT-1:0]        sts_q, hit, lvl_q, en_q;
  logic [NT-1:0]        clr;
  logic [NT-1:0][31:0]  trd;
  logic [31:0]          rmux;

  wire run = gcfg_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) gcfg_q <= '0;
    else if (wr_en && wr_addr == A_GCFG) gcfg_q <= wr_data[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr_en && wr_addr == A_CLO) cnt_q[31:0] <= wr_data;
    else if (wr_en && wr_addr == A_CHI) cnt_q[63:32] <= wr_data;
    else if (run) cnt_q <= cnt_q + 64'd1;
  end

  assign clr = (wr_en && wr_addr == A_STS) ? wr_data[NT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else sts_q <= (sts_q & ~clr) | hit;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam logic [AW-1:0] A_CFG = AW'(256 + 32 * i);
    localparam logic [AW-1:0] A_CML = AW'(256 + 32 * i + 8);
    localparam logic [AW-1:0] A_CMH = AW'(256 + 32 * i + 12);
    localparam logic [AW-1:0] A_RTE = AW'(256 + 32 * i + 16);

    logic        lvl, en, per, sv, m32, pend;
    logic [4:0]  rte;
    logic [63:0] cmp, prd;
    logic [31:0] route, rw;

    wire w_cfg = wr_en && wr_addr == A_CFG;
    wire w_lo  = wr_en && wr_addr == A_CML;
    wire w_hi  = wr_en && wr_addr == A_CMH;

    assign hit[i]   = run && (m32 ? (cnt_q[31:0] == cmp[31:0]) : (cnt_q == cmp));
    assign irq_o[i] = en && (lvl ? sts_q[i] : hit[i]);
    assign lvl_q[i] = lvl;
    assign en_q[i]  = en;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        {lvl, en, per, sv, m32, pend} <= '0;
        rte   <= '0;
        cmp   <= '1;
        prd   <= '0;
        route <= '0;
      end else begin
        if (w_cfg) begin
          lvl  <= wr_data[1];
          en   <= wr_data[2];
          per  <= wr_data[3];
          sv   <= wr_data[6];
          m32  <= wr_data[8];
          rte  <= wr_data[13:9];
          pend <= 1'b0;
        end
        if (wr_en && wr_addr == A_RTE) route <= wr_data;
        if (w_lo) begin
          if (pend) begin
            prd[31:0] <= wr_data;
            pend      <= 1'b0;
          end else begin
            cmp[31:0] <= wr_data;
            if (sv) begin
              sv   <= 1'b0;
              pend <= 1'b1;
            end
          end
        end else if (w_hi) begin
          if (pend) prd[63:32] <= wr_data;
          else      cmp[63:32] <= wr_data;
        end else if (hit[i] && per) begin
          cmp <= m32 ? {cmp[63:32], cmp[31:0] + prd[31:0]} : cmp + prd;
        end
      end
    end

    always_comb begin
      case (rd_addr)
        A_CFG:   rw = {16'b0, 2'b00, rte, m32, 1'b0, sv, 2'b11, per, en, lvl, 1'b0};
        A_CML:   rw = cmp[31:0];
        A_CMH:   rw = cmp[63:32];
        A_RTE:   rw = route;
        default: rw = '0;
      endcase
    end
    assign trd[i] = rw;
  end

  always_comb begin
    case (rd_addr)
      A_ID:    rmux = {VENDOR_ID, 2'b00, 1'b1, NT_M1, REVISION};
      A_TICK:  rmux = TICK_FS;
      A_GCFG:  rmux = {30'b0, gcfg_q};
      A_STS:   rmux = 32'(sts_q);
      A_CLO:   rmux = cnt_q[31:0];
      A_CHI:   rmux = cnt_q[63:32];
      default: rmux = '0;
    endcase
    for (int i = 0; i < NT; i++) rmux = rmux | trd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rmux;
    end
  end
endmodule

module event_timer_chk #(
  parameter int NUM_TIMERS = 3,
  parameter int AW         = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [AW-1:0]         wr_addr,
  input logic                  run,
  input logic [63:0]           cnt,
  input logic [NUM_TIMERS-1:0] hit,
  input logic [NUM_TIMERS-1:0] sts,
  input logic [NUM_TIMERS-1:0] lvl,
  input logic [NUM_TIMERS-1:0] en,
  input logic [NUM_TIMERS-1:0] irq,
  input logic                  rd_en,
  input logic [AW-1:0]         rd_addr,
  input logic [31:0]           rd_data,
  input logic                  rd_valid
);
  wire cnt_wr = wr_en && (wr_addr == AW'('h0F0) || wr_addr == AW'('h0F4));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> cnt == $past(cnt) + 64'd1);
  // R13
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R13
  rd_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == AW'('h0F8)) |=> rd_data == 32'h0);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    // R5
    sts_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[i]) |-> $past(hit[i]));
    // R7
    sts_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> sts[i]);
    // R8
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && lvl[i] && irq[i] && !wr_en) |=> irq[i]);
  end
endmodule

bind event_timer event_timer_chk #(.NUM_TIMERS(NUM_TIMERS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .run(gcfg_q[0]), .cnt(cnt_q), .hit(hit), .sts(sts_q),
  .lvl(lvl_q), .en(en_q), .irq(irq_o),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/event_timer_test.sv
module event_timer_test;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [9:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [2:0]  irq_o;

  int checks = 0, errors = 0, pulses1 = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  event_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_o(irq_o));

  always #4 clk = ~clk;

  always @(posedge clk) if (irq_o[1]) pulses1++;

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: got %h expected none", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0;
    idle(3);
    rst_n = 1;
    idle(1);
    // reset state
    chk(32'(irq_o), 0, "R8 irq after reset");
    rd('h000, 32'hC0DE_2201, "R1 id word");
    rd('h004, 32'd69841279, "R1 tick period");
    rd('h010, 0, "R2 gcfg reset");
    rd('h020, 0, "R7 status reset");
    rd('h0F0, 0, "R2 counter reset");
    rd('h100, 32'h30, "R4 cfg reset caps");
    rd('h108, 32'hFFFF_FFFF, "R5 comparator reset");
    // R13 holes
    wr('h0F8, 32'hFFFF);
    wr('h0F2, 32'h1234);
    rd('h0F8, 0, "R13 hole reads zero");
    rd('h0F2, 0, "R13 unaligned reads zero");
    rd('h0F0, 0, "R13 hole write ignored");
    // R3 counter writes
    wr('h0F0, 32'h100);
    wr('h0F4, 32'h5);
    rd('h0F0, 32'h100, "R3 counter low write");
    rd('h0F4, 32'h5, "R3 counter high write");
    // R2 enable for 10 clocks
    wr('h010, 1);
    idle(9);
    wr('h010, 2);
    rd('h0F0, 32'h10A, "R2 counted run");
    rd('h010, 2, "R2 gcfg readback");
    idle(3);
    rd('h0F0, 32'h10A, "R2 halted hold");
    wr('h010, 0);
    // R4 layout
    wr('h100, 32'hFFFF_FFFF);
    rd('h100, 32'h3F7E, "R4 cfg writable bits");
    wr('h100, 0);
    rd('h100, 32'h30, "R4 cfg cleared");
    wr('h110, 32'hA5A5);
    rd('h110, 32'hA5A5, "R4 route word");
    // R5 R8 one-shot level
    wr('h0F0, 0); wr('h0F4, 0);
    wr('h108, 20); wr('h10C, 0);
    wr('h100, 32'h6);
    wr('h010, 1);
    idle(10);
    chk(32'(irq_o[0]), 0, "R8 no irq before match");
    rd('h020, 0, "R5 no status before match");
    idle(15);
    chk(32'(irq_o[0]), 1, "R8 level irq after match");
    wr('h010, 0);
    rd('h020, 1, "R5 status after match");
    rd('h108, 20, "R10 one-shot comparator kept");
    // R7 write 0 then write 1
    wr('h020, 0);
    rd('h020, 1, "R7 write zero no effect");
    chk(32'(irq_o[0]), 1, "R8 irq held");
    wr('h020, 1);
    rd('h020, 0, "R7 write one clears");
    chk(32'(irq_o[0]), 0, "R8 irq drops on clear");
    // R5 R6 full vs narrowed compare
    wr('h0F0, 0); wr('h0F4, 1);
    wr('h108, 5);
    wr('h14C, 7); wr('h148, 5);
    wr('h140, 32'h106);
    wr('h010, 1);
    idle(10);
    wr('h010, 0);
    rd('h020, 32'h4, "R6 only narrowed timer matches");
    chk(32'(irq_o), 32'h4, "R6 irq of narrowed timer");
    wr('h020, 7);
    // R11 R10 R9 periodic edge timer 1
    wr('h0F0, 0); wr('h0F4, 0);
    wr('h120, 32'h4C);
    wr('h12C, 0);
    wr('h128, 10);
    wr('h128, 8);
    rd('h120, 32'h3C, "R11 load-next self clears");
    rd('h128, 10, "R11 comparator loaded");
    rd('h12C, 0, "R11 comparator high");
    p0 = pulses1;
    wr('h010, 1);
    idle(29);
    wr('h010, 0);
    rd('h128, 34, "R10 comparator advanced by interval");
    rd('h0F0, 30, "R2 counter after periodic run");
    chk(32'(pulses1 - p0), 3, "R9 one pulse per match");
    chk(32'(irq_o[1]), 0, "R9 edge line not held");
    rd('h020, 32'h7, "R9 status still set");
    // R12 write beats reload
    wr('h020, 7);
    wr('h0F0, 0);
    wr('h128, 5);
    wr('h010, 1);
    idle(5);
    wr('h128, 100);
    wr('h010, 0);
    rd('h128, 100, "R12 software write wins");
    rd('h020, 32'h7, "R12 match still flagged");
    // R7 clear vs match collision
    wr('h020, 7);
    wr('h0F0, 0);
    wr('h128, 5);
    wr('h010, 1);
    idle(5);
    wr('h020, 7);
    wr('h010, 0);
    rd('h020, 32'h7, "R7 match wins over clear");
    rd('h128, 13, "R10 reload after match");
    idle(2);
    chk(32'(exp_q.size()), 0, "R13 all reads answered");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule